// File: doc/BRIEF.md
# Overloaded Command Dispatch Router

This block executes a family of eight overloaded two-source, one-destination command opcodes. Each command carries an opcode index `k` (0 to 7) and two operands. The low twelve bits of the first operand hold a run-time handle. The router looks that handle up in a programmable table to find a target device port and a 12-bit subdevice number. It then merges the subdevice number with `k` into one selector and sends the selector, both full operands and a request strobe to that device. The device's answer comes back as the command's destination value.

Some handles never reach a device. Two handle values are built-in fallbacks that answer at once with zero or with all ones. Handle zero, and any handle with no valid table entry, raise an illegal-instruction trap. A device that gets a selector it does not implement answers with an error flag, and the router reports this as a separate trap cause. One device can sit behind several handles with different subdevice numbers, so a single device can expose several command interfaces.

The router holds one command at a time. The core offers a command with `cmd_valid` while `busy` is low. The result comes back with a one-cycle `done` pulse, or the command ends with a one-cycle `trap` pulse. The table is written through a simple per-entry configuration port.

Top module: `cmd_router`

## Requirements
- R1: The handle is `cmd_op_a[11:0]`; while a device request is active, `dev_op_a` and `dev_op_b` equal the accepted `cmd_op_a` and `cmd_op_b` unchanged, all bits included.
- R2: The selector on `dev_sel` is 15 bits: `dev_sel[14:12]` is the opcode index `k` and `dev_sel[11:0]` is the subdevice number of the matching table entry.
- R3: Handle 0, or a handle with no valid table entry, ends the command with a one-cycle `trap` pulse with `trap_cause` = 2'b01, without `done` and without any `dev_req`. `trap_cause` is 2'b00 whenever `trap` is low.
- R4: Handle 1 ends with `done` and `result` = 0; handle 2 ends with `done` and `result` = all ones. Both answer one cycle after acceptance and raise no `dev_req`. Table entries holding handle 0, 1 or 2 have no effect.
- R5: For a mapped handle, `dev_req` is one-hot on the entry's device index from the cycle after acceptance. It holds, with `dev_sel` and the operands stable, until that device raises `dev_ack`. Acks and errors from other device ports are ignored.
- R6: An ack from the selected device with `dev_err` low gives a one-cycle `done` pulse on the next cycle, with `result` equal to that device's `dev_rdata` slice (`dev_rdata[d*32 +: 32]` for device d).
- R7: An ack from the selected device with `dev_err` high ends the command with a one-cycle `trap` pulse with `trap_cause` = 2'b10, and no `done`.
- R8: A command is accepted only when `busy` is low. `cmd_valid` while busy is ignored. `busy` is high from the cycle after acceptance through the `done` or `trap` cycle, and low on the cycle after.
- R9: `cfg_we` writes table entry `cfg_idx` with {`cfg_valid`, `cfg_handle`, `cfg_dev`, `cfg_sub`}. Several entries may target one device with different subdevice numbers. When two valid entries hold the same handle, the lower index wins. Clearing `cfg_valid` unmaps the handle.
- R10: Reset invalidates every table entry and leaves `busy`, `done`, `trap` and `dev_req` low and `trap_cause` at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered by the core |
| cmd_k | input | 3 | Opcode index k |
| cmd_op_a | input | 32 | First operand, handle in bits 11:0 |
| cmd_op_b | input | 32 | Second operand |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 32 | Destination value, valid with done |
| trap | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | 01 unmapped handle, 10 device configuration error |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 3 | Table entry index |
| cfg_valid | input | 1 | Entry valid bit to write |
| cfg_handle | input | 12 | Handle to write |
| cfg_dev | input | 2 | Device index to write |
| cfg_sub | input | 12 | Subdevice number to write |
| dev_req | output | 4 | Per-device request strobe |
| dev_sel | output | 15 | Selector {k, subdevice}, shared by all devices |
| dev_op_a | output | 32 | First operand to devices |
| dev_op_b | output | 32 | Second operand to devices |
| dev_ack | input | 4 | Per-device acknowledge |
| dev_err | input | 4 | Per-device unimplemented-selector flag, read with ack |
| dev_rdata | input | 128 | Per-device results, 32 bits per device |

## Verification
The bench builds the router with its defaults: four device ports, an eight-entry table and 32-bit operands. At this size every table slot can be filled at once, including a duplicate handle, an entry that tries to override a fallback, and an entry whose subdevice the device rejects. Bench-side device models answer after a random delay and can raise a stray ack with an error on a neighbouring port. So the held-request rule, the selector merge and the foreign-ack filtering are all exercised on every device index. Random commands mix all eight opcode indices, the fallbacks, mapped, unmapped and rejected handles, and operands held on `cmd_valid` while busy.

// File: rtl/cmd_router_pkg.sv
package cmd_router_pkg;

  localparam int HANDLE_W = 12;
  localparam int CMD_W    = 3;
  localparam int SEL_W    = HANDLE_W + CMD_W;

  localparam logic [HANDLE_W-1:0] H_TRAP     = 12'd0;
  localparam logic [HANDLE_W-1:0] H_RET_ZERO = 12'd1;
  localparam logic [HANDLE_W-1:0] H_RET_ONES = 12'd2;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_UNMAPPED = 2'b01,
    CAUSE_CFGERR   = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_FIN  = 2'b10
  } state_e;

endpackage

// File: rtl/cmd_router_table.sv
module cmd_router_table
  import cmd_router_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int DEV_W   = 2,
  parameter int IDX_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_valid,
  input  logic [HANDLE_W-1:0] wr_handle,
  input  logic [DEV_W-1:0]    wr_dev,
  input  logic [HANDLE_W-1:0] wr_sub,
  input  logic [HANDLE_W-1:0] lk_handle,
  output logic                lk_hit,
  output logic [DEV_W-1:0]    lk_dev,
  output logic [HANDLE_W-1:0] lk_sub
);

  logic [NUM_ENT-1:0]  ent_vld_q;
  logic [HANDLE_W-1:0] ent_handle_q [NUM_ENT];
  logic [DEV_W-1:0]    ent_dev_q    [NUM_ENT];
  logic [HANDLE_W-1:0] ent_sub_q    [NUM_ENT];
  logic [NUM_ENT-1:0]  ent_match;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic ent_wr;
    assign ent_wr = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld_q[e] <= 1'b0;
      end else if (ent_wr) begin
        ent_vld_q[e] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_wr) begin
        ent_handle_q[e] <= wr_handle;
        ent_dev_q[e]    <= wr_dev;
        ent_sub_q[e]    <= wr_sub;
      end
    end

    assign ent_match[e] = ent_vld_q[e] && (ent_handle_q[e] == lk_handle);
  end

  // Walk from the top down so the lowest matching index is the last to win.
  always_comb begin
    lk_hit = 1'b0;
    lk_dev = '0;
    lk_sub = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (ent_match[e]) begin
        lk_hit = 1'b1;
        lk_dev = ent_dev_q[e];
        lk_sub = ent_sub_q[e];
      end
    end
  end

endmodule

// File: rtl/cmd_router_devmux.sv
module cmd_router_devmux #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2,
  parameter int XLEN    = 32
) (
  input  logic [DEV_W-1:0]        dev_idx,
  input  logic [NUM_DEV-1:0]      dev_ack,
  input  logic [NUM_DEV-1:0]      dev_err,
  input  logic [NUM_DEV*XLEN-1:0] dev_rdata,
  output logic                    rsp_ack,
  output logic                    rsp_err,
  output logic [XLEN-1:0]         rsp_data
);

  logic [XLEN-1:0] data_arr [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_unpack
    assign data_arr[d] = dev_rdata[d*XLEN +: XLEN];
  end

  assign rsp_ack  = dev_ack[dev_idx];
  assign rsp_err  = dev_err[dev_idx];
  assign rsp_data = data_arr[dev_idx];

endmodule

// File: rtl/cmd_router_ctrl.sv
module cmd_router_ctrl
  import cmd_router_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2,
  parameter int XLEN    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [CMD_W-1:0]    cmd_k,
  input  logic [XLEN-1:0]     cmd_op_a,
  input  logic [XLEN-1:0]     cmd_op_b,
  input  logic                lk_hit,
  input  logic [DEV_W-1:0]    lk_dev,
  input  logic [HANDLE_W-1:0] lk_sub,
  input  logic                rsp_ack,
  input  logic                rsp_err,
  input  logic [XLEN-1:0]     rsp_data,
  output logic                busy,
  output logic                done,
  output logic                trap,
  output logic [1:0]          trap_cause,
  output logic [XLEN-1:0]     result,
  output logic [DEV_W-1:0]    dev_idx,
  output logic [NUM_DEV-1:0]  dev_req,
  output logic [SEL_W-1:0]    dev_sel,
  output logic [XLEN-1:0]     dev_op_a,
  output logic [XLEN-1:0]     dev_op_b
);

  state_e              state_q, state_d;
  logic                done_q, done_d;
  logic                trap_q, trap_d;
  cause_e              cause_q, cause_d;
  logic [DEV_W-1:0]    dev_q, dev_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [XLEN-1:0]     a_q, b_q;
  logic [XLEN-1:0]     res_q, res_d;
  logic                load_cmd, load_res;
  logic [HANDLE_W-1:0] handle;

  assign handle = cmd_op_a[HANDLE_W-1:0];

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    trap_d   = 1'b0;
    cause_d  = CAUSE_NONE;
    dev_d    = dev_q;
    sel_d    = sel_q;
    res_d    = res_q;
    load_cmd = 1'b0;
    load_res = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load_cmd = 1'b1;
          state_d  = ST_FIN;
          if (handle == H_RET_ZERO) begin
            done_d   = 1'b1;
            load_res = 1'b1;
            res_d    = '0;
          end else if (handle == H_RET_ONES) begin
            done_d   = 1'b1;
            load_res = 1'b1;
            res_d    = '1;
          end else if (handle != H_TRAP && lk_hit) begin
            state_d = ST_WAIT;
            dev_d   = lk_dev;
            sel_d   = {cmd_k, lk_sub};
          end else begin
            trap_d  = 1'b1;
            cause_d = CAUSE_UNMAPPED;
          end
        end
      end
      ST_WAIT: begin
        if (rsp_ack) begin
          state_d = ST_FIN;
          if (rsp_err) begin
            trap_d  = 1'b1;
            cause_d = CAUSE_CFGERR;
          end else begin
            done_d   = 1'b1;
            load_res = 1'b1;
            res_d    = rsp_data;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_cmd) begin
      dev_q <= dev_d;
      sel_q <= sel_d;
      a_q   <= cmd_op_a;
      b_q   <= cmd_op_b;
    end
    if (load_res) begin
      res_q <= res_d;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_req
    assign dev_req[d] = (state_q == ST_WAIT) && (dev_q == DEV_W'(d));
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign trap       = trap_q;
  assign trap_cause = cause_q;
  assign result     = res_q;
  assign dev_idx    = dev_q;
  assign dev_sel    = sel_q;
  assign dev_op_a   = a_q;
  assign dev_op_b   = b_q;

endmodule

// File: rtl/cmd_router.sv
module cmd_router
  import cmd_router_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int NUM_ENT = 8,
  parameter int XLEN    = 32,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_k,
  input  logic [XLEN-1:0]         cmd_op_a,
  input  logic [XLEN-1:0]         cmd_op_b,
  output logic                    busy,
  output logic                    done,
  output logic [XLEN-1:0]         result,
  output logic                    trap,
  output logic [1:0]              trap_cause,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic                    cfg_valid,
  input  logic [11:0]             cfg_handle,
  input  logic [DEV_W-1:0]        cfg_dev,
  input  logic [11:0]             cfg_sub,
  output logic [NUM_DEV-1:0]      dev_req,
  output logic [14:0]             dev_sel,
  output logic [XLEN-1:0]         dev_op_a,
  output logic [XLEN-1:0]         dev_op_b,
  input  logic [NUM_DEV-1:0]      dev_ack,
  input  logic [NUM_DEV-1:0]      dev_err,
  input  logic [NUM_DEV*XLEN-1:0] dev_rdata
);

  logic                lk_hit;
  logic [DEV_W-1:0]    lk_dev;
  logic [HANDLE_W-1:0] lk_sub;
  logic [DEV_W-1:0]    dev_idx;
  logic                rsp_ack, rsp_err;
  logic [XLEN-1:0]     rsp_data;

  cmd_router_table #(
    .NUM_ENT(NUM_ENT), .DEV_W(DEV_W), .IDX_W(IDX_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_valid  (cfg_valid),
    .wr_handle (cfg_handle),
    .wr_dev    (cfg_dev),
    .wr_sub    (cfg_sub),
    .lk_handle (cmd_op_a[HANDLE_W-1:0]),
    .lk_hit    (lk_hit),
    .lk_dev    (lk_dev),
    .lk_sub    (lk_sub)
  );

  cmd_router_devmux #(
    .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .XLEN(XLEN)
  ) u_mux (
    .dev_idx   (dev_idx),
    .dev_ack   (dev_ack),
    .dev_err   (dev_err),
    .dev_rdata (dev_rdata),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
  );

  cmd_router_ctrl #(
    .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .XLEN(XLEN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_k      (cmd_k),
    .cmd_op_a   (cmd_op_a),
    .cmd_op_b   (cmd_op_b),
    .lk_hit     (lk_hit),
    .lk_dev     (lk_dev),
    .lk_sub     (lk_sub),
    .rsp_ack    (rsp_ack),
    .rsp_err    (rsp_err),
    .rsp_data   (rsp_data),
    .busy       (busy),
    .done       (done),
    .trap       (trap),
    .trap_cause (trap_cause),
    .result     (result),
    .dev_idx    (dev_idx),
    .dev_req    (dev_req),
    .dev_sel    (dev_sel),
    .dev_op_a   (dev_op_a),
    .dev_op_b   (dev_op_b)
  );

endmodule

// File: rtl/cmd_router_chk.sv
module cmd_router_chk #(
  parameter int NUM_DEV = 4,
  parameter int XLEN    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               trap,
  input logic [1:0]         trap_cause,
  input logic [NUM_DEV-1:0] dev_req,
  input logic [NUM_DEV-1:0] dev_ack,
  input logic [NUM_DEV-1:0] dev_err,
  input logic [14:0]        dev_sel,
  input logic [XLEN-1:0]    dev_op_a,
  input logic [XLEN-1:0]    dev_op_b
);

  logic sel_ack, sel_err;
  assign sel_ack = |(dev_req & dev_ack);
  assign sel_err = |(dev_req & dev_ack & dev_err);

  a_r5_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_req));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req && !sel_ack) |=>
      (dev_req == $past(dev_req)) && $stable(dev_sel) && $stable(dev_op_a) && $stable(dev_op_b));

  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ack && !sel_err) |=> done && !trap);

  a_r7_cfgerr_trap: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> trap && (trap_cause == 2'b10) && !done);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap));

  a_r3_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> (trap_cause == 2'b00));

  a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap) |=> !busy);

  a_r8_finish_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap || |dev_req) |-> busy);

endmodule

bind cmd_router cmd_router_chk #(.NUM_DEV(NUM_DEV), .XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .trap       (trap),
  .trap_cause (trap_cause),
  .dev_req    (dev_req),
  .dev_ack    (dev_ack),
  .dev_err    (dev_err),
  .dev_sel    (dev_sel),
  .dev_op_a   (dev_op_a),
  .dev_op_b   (dev_op_b)
);

// File: tb/tb_cmd_router.sv
`timescale 1ns/1ps
module tb_cmd_router;

  localparam int ND = 4;
  localparam int NE = 8;
  localparam int XL = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cmd_valid;
  logic [2:0]     cmd_k;
  logic [XL-1:0]  cmd_op_a, cmd_op_b;
  logic           busy, done, trap;
  logic [XL-1:0]  result;
  logic [1:0]     trap_cause;
  logic           cfg_we, cfg_valid;
  logic [2:0]     cfg_idx;
  logic [11:0]    cfg_handle, cfg_sub;
  logic [1:0]     cfg_dev;
  logic [ND-1:0]  dev_req, dev_ack, dev_err;
  logic [14:0]    dev_sel;
  logic [XL-1:0]  dev_op_a, dev_op_b;
  logic [ND*XL-1:0] dev_rdata;

  always #5 clk = ~clk;

  cmd_router dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  // bench copy of the table
  bit         m_vld [NE];
  bit [11:0]  m_hdl [NE];
  bit [1:0]   m_dev [NE];
  bit [11:0]  m_sub [NE];

  // device model controls and observations
  int         lat_cfg = 0;
  bit         stray_en = 0;
  bit         armed = 0;
  int         wait_cnt = 0;
  int         req_cycles = 0;
  logic [ND-1:0] obs_req;
  logic [14:0]   obs_sel;
  logic [XL-1:0] obs_a, obs_b;

  function automatic logic [XL-1:0] dev_fn(int d, logic [14:0] s, logic [XL-1:0] a, logic [XL-1:0] b);
    return (a ^ {s, 17'h0}) + b + XL'(d) * 32'h0101_0101;
  endfunction

  function automatic bit dev_rejects(logic [14:0] s);
    return s[11:0] >= 12'd3;
  endfunction

  always @(negedge clk) begin
    dev_ack <= '0;
    dev_err <= '0;
    if (rst_n && |dev_req) begin
      req_cycles <= req_cycles + 1;
      if (!armed) begin
        armed    <= 1'b1;
        wait_cnt <= lat_cfg;
      end else if (wait_cnt == 0) begin
        armed <= 1'b0;
        for (int d = 0; d < ND; d++) begin
          if (dev_req[d]) begin
            logic [ND-1:0] ack_v, err_v;
            logic [ND*XL-1:0] rd;
            ack_v = '0; err_v = '0;
            for (int o = 0; o < ND; o++) rd[o*XL +: XL] = 32'hBAD0_0000 + XL'(o);
            ack_v[d] = 1'b1;
            err_v[d] = dev_rejects(dev_sel);
            rd[d*XL +: XL] = dev_fn(d, dev_sel, dev_op_a, dev_op_b);
            if (stray_en) begin
              ack_v[(d+1)%ND] = 1'b1;
              err_v[(d+1)%ND] = 1'b1;
            end
            dev_ack   <= ack_v;
            dev_err   <= err_v;
            dev_rdata <= rd;
            obs_req   <= dev_req;
            obs_sel   <= dev_sel;
            obs_a     <= dev_op_a;
            obs_b     <= dev_op_b;
          end
        end
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input bit v, input logic [11:0] h, input logic [1:0] d, input logic [11:0] s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v; cfg_handle = h; cfg_dev = d; cfg_sub = s;
    @(negedge clk);
    cfg_we = 1'b0;
    m_vld[idx] = v; m_hdl[idx] = h; m_dev[idx] = d; m_sub[idx] = s;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cfg_we = 1'b0;
    for (int e = 0; e < NE; e++) m_vld[e] = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !trap && dev_req == '0 && trap_cause == 2'b00, "R10 reset outputs",
        XL'({busy, done, trap, dev_req, trap_cause}), '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 done, 1 trap
  task automatic run_cmd(input logic [2:0] k, input logic [XL-1:0] a, input logic [XL-1:0] b,
                         input int lat, input bit stray, input bit hold);
    logic [11:0] h;
    bit          exp_trap, hit, to_dev;
    logic [1:0]  exp_cause, hd;
    logic [11:0] hs;
    logic [14:0] exp_sel;
    logic [XL-1:0] exp_res;
    int          rc0, waited;
    h = a[11:0];
    hit = 0; hd = 0; hs = 0;
    for (int e = NE - 1; e >= 0; e--)
      if (m_vld[e] && m_hdl[e] == h) begin hit = 1; hd = m_dev[e]; hs = m_sub[e]; end
    exp_sel = {k, hs};
    to_dev = 0; exp_trap = 0; exp_cause = 2'b00; exp_res = '0;
    if (h == 12'd1)      exp_res = '0;
    else if (h == 12'd2) exp_res = '1;
    else if (h != 12'd0 && hit) begin
      to_dev = 1;
      if (dev_rejects(exp_sel)) begin exp_trap = 1; exp_cause = 2'b10; end
      else exp_res = dev_fn(int'(hd), exp_sel, a, b);
    end else begin
      exp_trap = 1; exp_cause = 2'b01;
    end
    lat_cfg = lat; stray_en = stray;
    rc0 = req_cycles;
    @(negedge clk);
    chk(!busy, "R8 idle before command", XL'(busy), '0);
    cmd_valid = 1'b1; cmd_k = k; cmd_op_a = a; cmd_op_b = b;
    @(negedge clk);
    if (hold) begin
      cmd_k = ~k; cmd_op_a = a ^ 32'h5A5A_0FF0; cmd_op_b = ~b;
    end else cmd_valid = 1'b0;
    chk(busy, "R8 busy after accept", XL'(busy), 1);
    waited = 0;
    while (!(done || trap) && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    cmd_valid = 1'b0;
    if (!to_dev)
      chk(waited == 0, "R3/R4 immediate answer", XL'(waited), 0);
    chk(trap == exp_trap && done == !exp_trap, exp_trap ? "R3/R7 trap raised" : "R4/R6 done raised",
        XL'({done, trap}), XL'({!exp_trap, exp_trap}));
    chk(trap_cause == (exp_trap ? exp_cause : 2'b00), "R3/R7 trap cause", XL'(trap_cause), XL'(exp_cause));
    if (!exp_trap)
      chk(result == exp_res, to_dev ? "R6 device result" : "R4 fallback result", result, exp_res);
    if (to_dev) begin
      chk(obs_req == ND'(1) << hd, "R5 device select", XL'(obs_req), XL'(ND'(1) << hd));
      chk(obs_sel == exp_sel, "R2 selector merge", XL'(obs_sel), XL'(exp_sel));
      chk(obs_a == a && obs_b == b, "R1 operands forwarded", obs_a ^ a, XL'(obs_b != b));
      chk(waited == lat + 2, "R5 request held until ack", XL'(waited), XL'(lat + 2));
    end else begin
      chk(req_cycles == rc0, "R3/R4 no device request", XL'(req_cycles - rc0), 0);
    end
    @(negedge clk);
    chk(!busy && !done && !trap, "R8 busy released", XL'({busy, done, trap}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_k = '0; cmd_op_a = '0; cmd_op_b = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_handle = '0; cfg_dev = '0; cfg_sub = '0;
    dev_ack = '0; dev_err = '0; dev_rdata = '0;
    obs_req = '0; obs_sel = '0; obs_a = '0; obs_b = '0;
    do_reset();

    // R9 table contents: shared devices, rejecting entry, fallback override, duplicate
    cfg_write(0, 1, 12'd32, 2'd0, 12'd0);
    cfg_write(1, 1, 12'd33, 2'd0, 12'd1);
    cfg_write(2, 1, 12'd34, 2'd1, 12'd0);
    cfg_write(3, 1, 12'd35, 2'd1, 12'd2);
    cfg_write(4, 1, 12'd36, 2'd2, 12'd7);
    cfg_write(5, 1, 12'd37, 2'd3, 12'd1);
    cfg_write(6, 1, 12'd1,  2'd2, 12'd0);
    cfg_write(7, 1, 12'd32, 2'd3, 12'd2);

    // directed corners
    run_cmd(3'd0, 32'hFFFF_F000, 32'h1234_5678, 0, 0, 0); // R3 handle zero
    run_cmd(3'd5, 32'h0000_1001, 32'h0,         0, 0, 0); // R4 zero fallback, table entry ignored
    run_cmd(3'd7, 32'hABCD_E002, 32'h9,         0, 0, 1); // R4 ones fallback
    run_cmd(3'd7, 32'h8000_0020, 32'hCAFE_F00D, 0, 0, 0); // R9 duplicate, lowest index (dev0)
    run_cmd(3'd2, 32'h1230_0021, 32'h1,         3, 1, 1); // R5 stray ack ignored, R2
    run_cmd(3'd4, 32'h0000_0024, 32'h2,         1, 0, 0); // R7 rejected selector
    run_cmd(3'd1, 32'h0000_0FFF, 32'h2,         0, 0, 0); // R3 unmapped
    run_cmd(3'd6, 32'h7000_0025, 32'h3,         2, 1, 0); // R5 device 3

    for (int i = 0; i < 400; i++) begin
      int pick;
      logic [11:0] h;
      pick = $urandom_range(0, 10);
      case (pick)
        0: h = 12'd0;
        1: h = 12'd1;
        2: h = 12'd2;
        9: h = 12'd38;
        10: h = 12'($urandom);
        default: h = 12'd32 + 12'(pick - 3);
      endcase
      run_cmd(3'($urandom), {20'($urandom), h}, $urandom, $urandom_range(0, 3),
              1'($urandom), 1'($urandom));
    end

    cfg_write(5, 0, 12'd37, 2'd3, 12'd1); // R9 invalidating unmaps
    run_cmd(3'd3, 32'h0000_0025, 32'h4, 0, 0, 0);
    do_reset();                           // R10 reset clears the table
    run_cmd(3'd3, 32'h0000_0021, 32'h4, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule